// File: doc/BRIEF.md
# Sine-Duty Pulse Width Modulator

This block turns a fast system clock into a single-bit pulse train with a fixed frame rate and a pulse width that follows a sine curve. An external low-pass filter followed by a switching power stage rebuilds a low-frequency sinusoid from that bit. At the default 50 MHz clock, a frame lasts 200 cycles, which gives a 250 kHz switching rate. Each frame begins by taking one sample from a 256-point sine table and loading it into a down-counter. The output stays high while the counter is non-zero, so the high time in cycles equals the sample value.

The table address is the upper byte of a 32-bit phase accumulator. The accumulator adds a tuning word once per frame. The sine frequency is therefore the frame rate times the tuning word divided by 2^32. A tuning word of 8589935 gives about 500 Hz. The table is centred on 100 with an amplitude of 96. The duty cycle therefore stays between 2% and 98% of the frame, which keeps a minimum pulse width for the power stage. When enable is low, the pulse output is held low and the timing restarts from phase zero.

Top module: `sine_pwm_gen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `pwm_o`, `frame_o` and `sample_o` all read 0 after that edge. The phase and the frame position return to zero.
- R2: While `en_i` is low (and reset is low), `pwm_o` and `frame_o` stay 0 from the next edge on and `sample_o` holds its value. The first frame after `en_i` is seen high starts at once: `frame_o` pulses on the next cycle with `sample_o` = 100, which is table entry 0.
- R3: While enabled, `frame_o` is a one-cycle pulse that repeats exactly every 200 clock cycles.
- R4: `pwm_o` rises only in a cycle where `frame_o` is 1. It then stays high for exactly N consecutive cycles, where N is the `sample_o` value shown with that pulse, and stays low for the rest of the frame.
- R5: `sample_o` changes only in cycles where `frame_o` is 1.
- R6: Table entry k (k = 0..255) equals round(100 + 96*sin(2*pi*k/256)), clamped to 4..196. Entry 0 is 100, entry 64 is 196 and entry 192 is 4. Every sample shown lies between 4 and 196.
- R7: The sample of a frame is read at address bits [31:24] of the phase before that frame's addition. The phase then adds the value on `tune_i` sampled in the cycle before the `frame_o` pulse, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low holds the output low and rewinds phase and frame timing |
| tune_i | input | 32 | Phase increment added once per frame |
| pwm_o | output | 1 | Pulse-width-modulated output |
| frame_o | output | 1 | One-cycle pulse in the first cycle of every frame |
| sample_o | output | 8 | Duty value (high cycles) of the current frame |

## Verification
The frame start does three things in one cycle: it loads the counter, it advances the phase, and it samples the tuning word. The bench makes other events land on that same cycle. It changes `tune_i` exactly in the strobe cycle. It drops `en_i` exactly in the strobe cycle, which must suppress the frame entirely. It raises reset in mid-frame. With a quarter-turn tuning word, a 196-cycle pulse ends four cycles before the next reload, and the reference model checks that neither the fall nor the reload is lost. A behavioural model of phase, table and frame position is compared with the outputs on every cycle, and a separate count of high cycles per frame is compared with each sample.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int FRAME_LEN_DEF = 200;
    localparam int ACC_W_DEF     = 32;
    localparam int ADDR_W_DEF    = 8;
    localparam int SAMP_W_DEF    = 8;
    localparam int MID_DEF       = 100;
    localparam int AMP_DEF       = 96;
    localparam int LO_DEF        = 4;
    localparam int HI_DEF        = 196;

    // Rounded sine code for point k of a table with pts points
    function automatic int sine_code(input int k, input int pts, input int mid, input int amp);
        real ang;
        ang = 2.0 * 3.141592653589793 * real'(k) / real'(pts);
        return $rtoi(real'(mid) + real'(amp) * $sin(ang) + 0.5);
    endfunction

    function automatic int clamp_code(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/spwm_frame_timer.sv
module spwm_frame_timer #(
    parameter  int FRAME_LEN = 200,
    localparam int CW        = $clog2(FRAME_LEN)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic start_o
);

    typedef struct packed {
        logic [CW-1:0] pos;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = en_i && (st_q.pos == '0);
        if (!en_i) begin
            st_d.pos = '0;
        end else if (st_q.pos == CW'(FRAME_LEN - 1)) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/spwm_phase_rom.sv
module spwm_phase_rom
    import spwm_pkg::*;
#(
    parameter  int ACC_W  = 32,
    parameter  int ADDR_W = 8,
    parameter  int SAMP_W = 8,
    parameter  int MID    = 100,
    parameter  int AMP    = 96,
    parameter  int LO     = 4,
    parameter  int HI     = 196,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              step_i,
    input  logic [ACC_W-1:0]  tune_i,
    output logic [SAMP_W-1:0] samp_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    logic [SAMP_W-1:0] rom [DEPTH];

    // Table filled once with clamped, rounded sine codes
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            rom[k] = SAMP_W'(clamp_code(sine_code(k, DEPTH, MID, AMP), LO, HI));
        end
    end

    always_comb begin
        st_d   = st_q;
        samp_o = rom[st_q.acc[ACC_W-1 -: ADDR_W]];
        if (!en_i) begin
            st_d.acc = '0;
        end else if (step_i) begin
            st_d.acc = st_q.acc + tune_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/spwm_duty_counter.sv
module spwm_duty_counter #(
    parameter int SAMP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [SAMP_W-1:0] val_i,
    output logic              pwm_o,
    output logic              frame_o,
    output logic [SAMP_W-1:0] sample_o
);

    typedef struct packed {
        logic [SAMP_W-1:0] cnt;
        logic              pwm;
        logic              frm;
        logic [SAMP_W-1:0] smp;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.frm = en_i && load_i;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (load_i) begin
            st_d.cnt = val_i;
            st_d.smp = val_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.pwm = (st_d.cnt != '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pwm_o    = st_q.pwm;
    assign frame_o  = st_q.frm;
    assign sample_o = st_q.smp;

endmodule

// File: rtl/sine_pwm_gen.sv
module sine_pwm_gen
    import spwm_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_LEN_DEF,
    parameter int ACC_W     = ACC_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int SAMP_W    = SAMP_W_DEF,
    parameter int MID       = MID_DEF,
    parameter int AMP       = AMP_DEF,
    parameter int LO        = LO_DEF,
    parameter int HI        = HI_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  tune_i,
    output logic              pwm_o,
    output logic              frame_o,
    output logic [SAMP_W-1:0] sample_o
);

    logic              start;
    logic [SAMP_W-1:0] samp;

    spwm_frame_timer #(
        .FRAME_LEN (FRAME_LEN)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .start_o (start)
    );

    spwm_phase_rom #(
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W),
        .SAMP_W (SAMP_W),
        .MID    (MID),
        .AMP    (AMP),
        .LO     (LO),
        .HI     (HI)
    ) u_phase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .step_i (start),
        .tune_i (tune_i),
        .samp_o (samp)
    );

    spwm_duty_counter #(
        .SAMP_W (SAMP_W)
    ) u_duty (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .load_i   (start),
        .val_i    (samp),
        .pwm_o    (pwm_o),
        .frame_o  (frame_o),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/spwm_checker.sv
module spwm_checker #(
    parameter  int FRAME_LEN = 200,
    parameter  int SAMP_W    = 8,
    parameter  int LO        = 4,
    parameter  int HI        = 196,
    localparam int GW        = $clog2(FRAME_LEN) + 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              en_i,
    input logic              pwm_o,
    input logic              frame_o,
    input logic [SAMP_W-1:0] sample_o
);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_o) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!pwm_o && !frame_o)); // R2

    AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_o && seen_q) |-> (gap_q == GW'(FRAME_LEN))); // R3

    AST_RISE_AT_FRAME: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pwm_o) |-> frame_o); // R4

    AST_FRAME_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |-> pwm_o); // R4

    AST_SAMPLE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_o |-> $stable(sample_o)); // R5

    AST_SAMPLE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |-> (sample_o >= SAMP_W'(LO) && sample_o <= SAMP_W'(HI))); // R6

endmodule

bind sine_pwm_gen spwm_checker #(
    .FRAME_LEN (FRAME_LEN),
    .SAMP_W    (SAMP_W),
    .LO        (LO),
    .HI        (HI)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .pwm_o    (pwm_o),
    .frame_o  (frame_o),
    .sample_o (sample_o)
);

// File: tb/tb_sine_pwm_gen.sv
module tb_sine_pwm_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] tune = '0;
    logic        pwm, frm;
    logic [7:0]  smp;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit started = 0;

    int tab [256];

    // reference state
    bit [31:0] m_acc = '0;
    int m_pos = 0, m_left = 0;
    bit e_pwm = 0, e_frm = 0;
    int e_smp = 0;

    // independent high-count tracking
    int hi_cnt = 0, frm_len = 0, prev_smp = 0;
    bit hv = 0, saw_max = 0, saw_min = 0;

    sine_pwm_gen dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .tune_i(tune),
        .pwm_o(pwm), .frame_o(frm), .sample_o(smp)
    );

    always #2 clk = ~clk;

    initial begin
        for (int k = 0; k < 256; k++) begin
            tab[k] = $rtoi(100.0 + 96.0 * $sin(2.0 * 3.141592653589793 * k / 256.0) + 0.5);
            if (tab[k] < 4) tab[k] = 4;
            if (tab[k] > 196) tab[k] = 196;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (rst) begin
            m_acc = '0; m_pos = 0; m_left = 0;
            e_pwm = 0; e_frm = 0; e_smp = 0;
        end else if (!en) begin
            m_acc = '0; m_pos = 0; m_left = 0;
            e_pwm = 0; e_frm = 0;
        end else begin
            if (m_pos == 0) begin
                m_left = tab[m_acc[31:24]];
                e_smp  = m_left;
                m_acc  = m_acc + tune;
                e_frm  = 1;
            end else begin
                if (m_left > 0) m_left--;
                e_frm = 0;
            end
            e_pwm = (m_left != 0);
            m_pos = (m_pos == 199) ? 0 : m_pos + 1;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check(pwm == e_pwm, (rst ? "R1 pwm" : (!en ? "R2 pwm" : "R4 pwm")), pwm, e_pwm);
            check(frm == e_frm, (rst ? "R1 frame" : (!en ? "R2 frame" : "R3 frame")), frm, e_frm);
            check(int'(smp) == e_smp, "R6 R7 sample", smp, e_smp);
            if (rst || !en) begin
                hv = 0;
            end else begin
                if (frm) begin
                    if (hv && frm_len == 200) begin
                        check(hi_cnt == prev_smp, "R4 high count", hi_cnt, prev_smp);
                    end
                    if (hv) check(frm_len == 200, "R3 frame length", frm_len, 200);
                    check(smp >= 4 && smp <= 196, "R6 range", smp, 100);
                    if (smp == 196) saw_max = 1;
                    if (smp == 4)   saw_min = 1;
                    hi_cnt = 0; frm_len = 0; prev_smp = smp; hv = 1;
                end
                hi_cnt += pwm;
                frm_len++;
            end
        end
    end

    task automatic frames(input int n);
        repeat (n * 200) @(negedge clk);
    endtask

    // leaves the next posedge as a strobe edge
    task automatic to_strobe_cycle();
        @(negedge clk);
        while (!frm) @(negedge clk);
        repeat (199) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pwm == 0 && frm == 0 && smp == 0, "R1 reset outputs", {pwm, frm, smp}, 0);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        check(pwm == 0 && frm == 0, "R2 idle while disabled", {pwm, frm}, 0);

        tune = 32'd8589935;
        en   = 1'b1;
        @(negedge clk);
        check(frm == 1, "R2 first frame immediate", frm, 1);
        check(smp == 100, "R2 first sample entry 0", smp, 100);
        frames(6);

        tune = 32'h4000_0000;
        frames(10);

        tune = 32'h0400_0000;
        frames(66);

        to_strobe_cycle();
        tune = 32'h0200_0000;   // R7 change lands in strobe cycle
        frames(3);

        to_strobe_cycle();
        en = 1'b0;              // R2 drop in strobe cycle
        @(negedge clk);
        check(frm == 0 && pwm == 0, "R2 frame suppressed", {frm, pwm}, 0);
        repeat (30) @(negedge clk);
        en = 1'b1;
        frames(3);

        repeat (77) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(smp == 0 && pwm == 0, "R1 mid-run reset", {smp, pwm}, 0);
        rst = 1'b0;
        frames(2);

        tune = 32'h0;
        frames(3);

        check(saw_max, "R6 peak 196 seen", saw_max, 1);
        check(saw_min, "R6 trough 4 seen", saw_min, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule